// File: doc/BRIEF.md
# AUX Request Framing and Retry Sequencer

This block sits between a requester and the register-level transfer port of a display auxiliary channel. A requester hands it one command: a 4-bit command code, a 20-bit target address, a length of 0 to 16 bytes and, for writes, a payload. The block turns the command into a message of at most 20 bytes. It waits for the channel to be free, launches the message and collects the outcome of every attempt. It relaunches after errors, then reduces the reply to a single status, the reply code, a byte count and any read data.

Requests enter on a valid/ready pair. Only one request is in flight: `req_ready` is high only while the block is idle, and a request is taken in the cycle where `req_valid` and `req_ready` are both high. Results leave on a second valid/ready pair. Once `rsp_valid` rises, the block holds it and every response field steady until `rsp_ready` is seen high, so the consumer can stall for as long as it likes. The channel side uses plain pins: a one-cycle `ch_start` pulse with the message, and a one-cycle `ch_done` pulse carrying the error flags and the received bytes.

Timing is set by parameters counted in clock cycles: the spacing of busy polls, the pause after a receive error, the number of attempts (3 or more) and the number of busy polls.

Top module: `aux_req_seq`

## Requirements
- R1: After reset `req_ready`=1, `rsp_valid`=0 and `ch_start`=0. `req_ready` is 1 only while no request is in flight. A response stays valid with stable fields until taken. Status codes: 0 OK, 1 receive error, 2 timeout, 3 busy, 4 illegal reply size, 5 invalid request.
- R2: Message byte k sits at `ch_tx_data[8k+7:8k]`. Byte 0 is {command, address[19:16]}, byte 1 is address[15:8], byte 2 is address[7:0], byte 3 is length−1, and for writes payload byte j (at `req_payload[8j+7:8j]`) follows as message byte 4+j.
- R3: `ch_tx_len` is 3 for a zero-length request. Otherwise it is 4+length for writes and 4 for reads.
- R4: With bit 2 of the command masked off, codes 1 and 9 are reads and codes 0, 2 and 8 are writes. Any other code, or a length above 16, gives status 5 with no `ch_start`.
- R5: The expected reply size is 2 for writes and length+1 for reads. A longer received size is clamped to it.
- R6: `rsp_reply` is bits 7:4 of received byte 0 and is passed up uninterpreted. For a read, `rsp_count` is the clamped size minus 1 and `rsp_data` byte j is received byte j+1, with zeros beyond the count.
- R7: For a write whose clamped reply size is 2, `rsp_count` is received byte 1, limited to the request length. Otherwise the full length is reported.
- R8: A received size of 0 or above 20 gives status 4, with reply and count 0.
- R9: After a timeout-only attempt with attempts left, `ch_start` pulses in the very next cycle.
- R10: After a receive error with attempts left, at least ERR_WAIT cycles pass before the next `ch_start`. A receive error takes precedence over a timeout flagged in the same completion.
- R11: At most MAX_TRIES launches are made per request, each a one-cycle pulse. When the last attempt fails, its error becomes the status (1 or 2) and reply and count read 0.
- R12: Before the first launch `ch_busy` is sampled up to BUSY_POLLS times, POLL_GAP cycles apart. If it is never low, status 3 is returned with no launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Payload/read length, 0 to 16 |
| req_payload | input | 128 | Write payload, byte j at bits 8j+7:8j |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_status | output | 3 | Final status code |
| rsp_reply | output | 4 | Reply code nibble |
| rsp_count | output | 5 | Bytes read or bytes accepted |
| rsp_data | output | 128 | Read data, byte j at bits 8j+7:8j |
| ch_busy | input | 1 | Channel occupied by earlier activity |
| ch_start | output | 1 | Launch pulse for one attempt |
| ch_tx_len | output | 5 | Message size in bytes |
| ch_tx_data | output | 160 | Message bytes |
| ch_done | input | 1 | Attempt finished, flags and reply valid |
| ch_timeout | input | 1 | Attempt ended without a reply |
| ch_rx_err | input | 1 | Attempt ended with a corrupt reply |
| ch_rx_len | input | 5 | Received byte count |
| ch_rx_data | input | 160 | Received bytes, byte k at bits 8k+7:8k |

## Verification
The assertions watch the control skeleton on every cycle. They check that each launch is a single pulse and stays within the attempt budget, and that a timeout leads to a relaunch in the next cycle while a receive error never does. They also check that busy and invalid outcomes carry no launch, that a stalled response holds steady, and that launched sizes stay between 3 and 20. The bench scenarios are what show the byte content: header packing, payload placement, clamping of oversized replies, short-write counts, the data offset for reads and the exact spacing of relaunches and busy polls.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_RXERR   = 3'd1,
    ST_TIMEOUT = 3'd2,
    ST_BUSY    = 3'd3,
    ST_BADSIZE = 3'd4,
    ST_INVALID = 3'd5
  } aux_status_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_BAD   = 2'd2
  } cmd_kind_e;

  // bit 2 marks a continued I2C transaction and does not change the class
  localparam logic [3:0] CONT_MASK = 4'b1011;

  function automatic cmd_kind_e classify_cmd(input logic [3:0] cmd);
    logic [3:0] base;
    base = cmd & CONT_MASK;
    case (base)
      4'h1, 4'h9:       return KIND_READ;
      4'h0, 4'h2, 4'h8: return KIND_WRITE;
      default:          return KIND_BAD;
    endcase
  endfunction

endpackage

// File: rtl/aux_frame_build.sv
module aux_frame_build
  import aux_seq_pkg::*;
#(
  parameter int MAX_PAYLOAD = 16,
  parameter int MSG_BYTES   = 20,
  parameter int LEN_W       = 5
) (
  input  logic [3:0]               cmd,
  input  logic [19:0]              addr,
  input  logic [LEN_W-1:0]         len,
  input  logic [MAX_PAYLOAD*8-1:0] payload,
  output cmd_kind_e                kind,
  output logic [LEN_W-1:0]         tx_len,
  output logic [LEN_W-1:0]         exp_rx_len,
  output logic [MSG_BYTES*8-1:0]   tx_data
);

  logic       is_wr;
  logic [7:0] len_m1;

  always_comb begin
    kind = classify_cmd(cmd);
    if (len > LEN_W'(MAX_PAYLOAD)) kind = KIND_BAD;
    is_wr  = (kind == KIND_WRITE);
    len_m1 = 8'(len) - 8'd1;
    if (len == '0)  tx_len = LEN_W'(3);
    else if (is_wr) tx_len = LEN_W'(4) + len;
    else            tx_len = LEN_W'(4);
    exp_rx_len = is_wr ? LEN_W'(2) : len + LEN_W'(1);
  end

  // header bytes
  assign tx_data[7:0]   = {cmd, addr[19:16]};
  assign tx_data[15:8]  = addr[15:8];
  assign tx_data[23:16] = addr[7:0];
  assign tx_data[31:24] = len_m1;

  // payload bytes follow the header for writes only
  for (genvar i = 4; i < MSG_BYTES; i++) begin : g_body
    localparam int P = i - 4;
    assign tx_data[i*8 +: 8] = (is_wr && (LEN_W'(P) < len)) ? payload[P*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode #(
  parameter int MAX_PAYLOAD = 16,
  parameter int MSG_BYTES   = 20,
  parameter int LEN_W       = 5
) (
  input  logic                     is_read,
  input  logic [LEN_W-1:0]         req_len,
  input  logic [LEN_W-1:0]         exp_rx_len,
  input  logic [LEN_W-1:0]         rx_len,
  input  logic [MSG_BYTES*8-1:0]   rx_data,
  output logic                     bad_size,
  output logic [3:0]               reply,
  output logic [LEN_W-1:0]         count,
  output logic [MAX_PAYLOAD*8-1:0] data
);

  logic [LEN_W-1:0] eff_len;
  logic [7:0]       accepted;
  logic             unused_rx;

  assign unused_rx = ^{rx_data[3:0], rx_data[MSG_BYTES*8-1:(MAX_PAYLOAD+1)*8]};

  always_comb begin
    bad_size = (rx_len == '0) || (rx_len > LEN_W'(MSG_BYTES));
    eff_len  = (rx_len > exp_rx_len) ? exp_rx_len : rx_len;
    reply    = rx_data[7:4];
    accepted = rx_data[15:8];
    if (is_read)
      count = (eff_len == '0) ? '0 : eff_len - LEN_W'(1);
    else if (eff_len > LEN_W'(1))
      count = (accepted < 8'(req_len)) ? accepted[LEN_W-1:0] : req_len;
    else
      count = req_len;
  end

  // read data starts one byte past the reply code
  for (genvar i = 0; i < MAX_PAYLOAD; i++) begin : g_rd
    assign data[i*8 +: 8] = (is_read && (LEN_W'(i) < count)) ? rx_data[(i+1)*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/aux_retry_fsm.sv
module aux_retry_fsm
  import aux_seq_pkg::*;
#(
  parameter int POLL_GAP   = 1000,
  parameter int ERR_WAIT   = 400,
  parameter int MAX_TRIES  = 5,
  parameter int BUSY_POLLS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_bad,
  input  logic        ch_busy,
  input  logic        ch_done,
  input  logic        ch_timeout,
  input  logic        ch_rx_err,
  input  logic        reply_bad,
  input  logic        rsp_ready,
  output logic        req_ready,
  output logic        ch_start,
  output logic        rsp_valid,
  output logic        take_reply,
  output aux_status_e status
);

  localparam int TMR_MAX = (POLL_GAP > ERR_WAIT) ? POLL_GAP : ERR_WAIT;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int TRY_W   = $clog2(MAX_TRIES + 1);
  localparam int POLL_W  = $clog2(BUSY_POLLS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_POLL, S_GAP, S_LAUNCH, S_WAIT, S_BACKOFF, S_RESP
  } state_e;

  state_e            state_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [TRY_W-1:0]  try_q;
  logic [POLL_W-1:0] poll_q;
  logic              last_try;

  assign last_try   = (try_q == TRY_W'(MAX_TRIES));
  assign req_ready  = (state_q == S_IDLE);
  assign ch_start   = (state_q == S_LAUNCH);
  assign rsp_valid  = (state_q == S_RESP);
  assign take_reply = (state_q == S_WAIT) && ch_done && !ch_rx_err && !ch_timeout && !reply_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      try_q   <= '0;
      poll_q  <= '0;
      status  <= ST_OK;
    end else begin
      case (state_q)
        S_IDLE: if (req_valid) begin
          state_q <= S_CHECK;
          try_q   <= '0;
          poll_q  <= '0;
        end
        S_CHECK: if (req_bad) begin
          status  <= ST_INVALID;
          state_q <= S_RESP;
        end else begin
          state_q <= S_POLL;
        end
        S_POLL: if (!ch_busy) begin
          state_q <= S_LAUNCH;
        end else if (poll_q == POLL_W'(BUSY_POLLS - 1)) begin
          status  <= ST_BUSY;
          state_q <= S_RESP;
        end else begin
          poll_q  <= poll_q + POLL_W'(1);
          tmr_q   <= '0;
          state_q <= S_GAP;
        end
        S_GAP: if (tmr_q == TMR_W'(POLL_GAP - 1)) state_q <= S_POLL;
               else tmr_q <= tmr_q + TMR_W'(1);
        S_LAUNCH: begin
          try_q   <= try_q + TRY_W'(1);
          state_q <= S_WAIT;
        end
        S_WAIT: if (ch_done) begin
          if (ch_rx_err) begin
            if (last_try) begin
              status  <= ST_RXERR;
              state_q <= S_RESP;
            end else begin
              tmr_q   <= '0;
              state_q <= S_BACKOFF;
            end
          end else if (ch_timeout) begin
            if (last_try) begin
              status  <= ST_TIMEOUT;
              state_q <= S_RESP;
            end else begin
              state_q <= S_LAUNCH;
            end
          end else begin
            status  <= reply_bad ? ST_BADSIZE : ST_OK;
            state_q <= S_RESP;
          end
        end
        S_BACKOFF: if (tmr_q == TMR_W'(ERR_WAIT - 1)) state_q <= S_LAUNCH;
                   else tmr_q <= tmr_q + TMR_W'(1);
        S_RESP: if (rsp_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |=> !ch_start);
  p_try_budget_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |-> (try_q < TRY_W'(MAX_TRIES)));
  p_timeout_relaunch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && ch_done && ch_timeout && !ch_rx_err && !last_try) |=> ch_start);
  p_rxerr_pause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && ch_done && ch_rx_err) |=> !ch_start);
  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(status)));
  p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && status == ST_INVALID) |-> (try_q == '0));
  p_busy_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && status == ST_BUSY) |-> (try_q == '0));

endmodule

// File: rtl/aux_req_seq.sv
module aux_req_seq
  import aux_seq_pkg::*;
#(
  parameter int MAX_PAYLOAD = 16,
  parameter int POLL_GAP    = 1000,
  parameter int ERR_WAIT    = 400,
  parameter int MAX_TRIES   = 5,
  parameter int BUSY_POLLS  = 3,
  localparam int MSG_BYTES  = MAX_PAYLOAD + 4,
  localparam int LEN_W      = $clog2(MSG_BYTES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [3:0]               req_cmd,
  input  logic [19:0]              req_addr,
  input  logic [LEN_W-1:0]         req_len,
  input  logic [MAX_PAYLOAD*8-1:0] req_payload,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [2:0]               rsp_status,
  output logic [3:0]               rsp_reply,
  output logic [LEN_W-1:0]         rsp_count,
  output logic [MAX_PAYLOAD*8-1:0] rsp_data,
  input  logic                     ch_busy,
  output logic                     ch_start,
  output logic [LEN_W-1:0]         ch_tx_len,
  output logic [MSG_BYTES*8-1:0]   ch_tx_data,
  input  logic                     ch_done,
  input  logic                     ch_timeout,
  input  logic                     ch_rx_err,
  input  logic [LEN_W-1:0]         ch_rx_len,
  input  logic [MSG_BYTES*8-1:0]   ch_rx_data
);

  logic [3:0]               cmd_q;
  logic [19:0]              addr_q;
  logic [LEN_W-1:0]         len_q;
  logic [MAX_PAYLOAD*8-1:0] payload_q;

  cmd_kind_e                kind;
  logic [LEN_W-1:0]         exp_rx_len;
  logic                     reply_bad;
  logic [3:0]               dec_reply;
  logic [LEN_W-1:0]         dec_count;
  logic [MAX_PAYLOAD*8-1:0] dec_data;
  logic                     take_reply;
  logic                     req_take;
  aux_status_e              status;

  assign req_take   = req_valid && req_ready;
  assign rsp_status = status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      addr_q    <= '0;
      len_q     <= '0;
      payload_q <= '0;
      rsp_reply <= '0;
      rsp_count <= '0;
      rsp_data  <= '0;
    end else if (req_take) begin
      cmd_q     <= req_cmd;
      addr_q    <= req_addr;
      len_q     <= req_len;
      payload_q <= req_payload;
      rsp_reply <= '0;
      rsp_count <= '0;
      rsp_data  <= '0;
    end else if (take_reply) begin
      rsp_reply <= dec_reply;
      rsp_count <= dec_count;
      rsp_data  <= dec_data;
    end
  end

  aux_frame_build #(
    .MAX_PAYLOAD(MAX_PAYLOAD), .MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W)
  ) u_build (
    .cmd(cmd_q), .addr(addr_q), .len(len_q), .payload(payload_q),
    .kind(kind), .tx_len(ch_tx_len), .exp_rx_len(exp_rx_len), .tx_data(ch_tx_data)
  );

  aux_reply_decode #(
    .MAX_PAYLOAD(MAX_PAYLOAD), .MSG_BYTES(MSG_BYTES), .LEN_W(LEN_W)
  ) u_decode (
    .is_read(kind == KIND_READ), .req_len(len_q), .exp_rx_len(exp_rx_len),
    .rx_len(ch_rx_len), .rx_data(ch_rx_data),
    .bad_size(reply_bad), .reply(dec_reply), .count(dec_count), .data(dec_data)
  );

  aux_retry_fsm #(
    .POLL_GAP(POLL_GAP), .ERR_WAIT(ERR_WAIT), .MAX_TRIES(MAX_TRIES), .BUSY_POLLS(BUSY_POLLS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bad(kind == KIND_BAD),
    .ch_busy(ch_busy), .ch_done(ch_done), .ch_timeout(ch_timeout), .ch_rx_err(ch_rx_err),
    .reply_bad(reply_bad), .rsp_ready(rsp_ready), .req_ready(req_ready),
    .ch_start(ch_start), .rsp_valid(rsp_valid), .take_reply(take_reply), .status(status)
  );

  p_txlen_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start |-> (ch_tx_len >= LEN_W'(3) && ch_tx_len <= LEN_W'(MSG_BYTES)));
  p_ready_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);

endmodule

// File: tb/tb_aux_req_seq.sv
module tb_aux_req_seq;

  localparam int CLK_PERIOD  = 10;
  localparam int MAX_PAYLOAD = 16;
  localparam int POLL_GAP    = 12;
  localparam int ERR_WAIT    = 9;
  localparam int MAX_TRIES   = 5;
  localparam int BUSY_POLLS  = 3;
  localparam int MSG_BYTES   = MAX_PAYLOAD + 4;
  localparam int LEN_W       = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_cmd = '0;
  logic [19:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [MAX_PAYLOAD*8-1:0] req_payload = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [2:0] rsp_status;
  logic [3:0] rsp_reply;
  logic [LEN_W-1:0] rsp_count;
  logic [MAX_PAYLOAD*8-1:0] rsp_data;
  logic ch_busy = 1'b0, ch_start;
  logic [LEN_W-1:0] ch_tx_len;
  logic [MSG_BYTES*8-1:0] ch_tx_data;
  logic ch_done = 1'b0, ch_timeout = 1'b0, ch_rx_err = 1'b0;
  logic [LEN_W-1:0] ch_rx_len = '0;
  logic [MSG_BYTES*8-1:0] ch_rx_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aux_req_seq #(.MAX_PAYLOAD(MAX_PAYLOAD), .POLL_GAP(POLL_GAP), .ERR_WAIT(ERR_WAIT),
                .MAX_TRIES(MAX_TRIES), .BUSY_POLLS(BUSY_POLLS)) dut (.*);

  int checks = 0, errors = 0;
  int cyc = 0, done_cyc = 0, countdown = 0;
  int n_starts = 0, cur_attempt = 0, n_kinds = 0, last_kind = 0, rx_n = 0;
  int out_kind [8];        // 0 ok, 1 timeout, 2 rx error, 3 both flags
  logic [7:0] rx_b [MSG_BYTES];
  logic [7:0] ex_tx [MSG_BYTES];
  int ex_tx_len = 0;
  bit in_flight = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // channel model and per-clock reference comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (ch_done) begin
        ch_done = 1'b0; ch_timeout = 1'b0; ch_rx_err = 1'b0;
      end
      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          automatic int k = (cur_attempt < n_kinds) ? out_kind[cur_attempt] : 0;
          ch_done = 1'b1;
          ch_timeout = (k == 1 || k == 3);
          ch_rx_err = (k == 2 || k == 3);
          ch_rx_len = LEN_W'(rx_n);
          for (int i = 0; i < MSG_BYTES; i++) ch_rx_data[i*8 +: 8] = rx_b[i];
          last_kind = k;
          done_cyc = cyc;
          cur_attempt++;
        end
      end
      if (rst_n) begin
        chk(req_ready == !in_flight, "R1", "req_ready vs model", req_ready, !in_flight);
        chk(!rsp_valid || in_flight, "R1", "rsp_valid outside request", rsp_valid, 0);
        if (ch_start) begin
          n_starts++;
          chk(in_flight && countdown == 0, "R11", "launch while idle or pending", 1, 0);
          if (n_starts > 1 && last_kind == 1)
            chk(cyc - done_cyc == 1, "R9", "timeout relaunch gap", cyc - done_cyc, 1);
          if (n_starts > 1 && last_kind >= 2)
            chk(cyc - done_cyc >= ERR_WAIT, "R10", "rx error relaunch gap", cyc - done_cyc, ERR_WAIT);
          chk(ch_tx_len == LEN_W'(ex_tx_len), "R3", "tx length", ch_tx_len, ex_tx_len);
          for (int i = 0; i < ex_tx_len; i++)
            chk(ch_tx_data[i*8 +: 8] == ex_tx[i], "R2", $sformatf("tx byte %0d", i),
                ch_tx_data[i*8 +: 8], ex_tx[i]);
          countdown = 3;
        end
      end
    end
  end

  task automatic set_rx(input int n, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input logic [7:0] b3);
    for (int i = 0; i < MSG_BYTES; i++) rx_b[i] = 8'(8'hA0 + i);
    rx_b[0] = b0; rx_b[1] = b1; rx_b[2] = b2; rx_b[3] = b3;
    rx_n = n;
  endtask

  task automatic do_req(input logic [3:0] cmd, input logic [19:0] addr, input int len,
                        input bit is_wr, input bit is_rd, input logic [127:0] pl,
                        input int ex_status, input int ex_reply, input int ex_count,
                        input int ex_starts, input string rq, input int hold);
    logic [127:0] exd;
    int acc_cyc;
    ex_tx[0] = {cmd, addr[19:16]};
    ex_tx[1] = addr[15:8];
    ex_tx[2] = addr[7:0];
    ex_tx[3] = 8'(len - 1);
    for (int i = 4; i < MSG_BYTES; i++) ex_tx[i] = 8'h00;
    if (is_wr) for (int i = 0; i < len; i++) ex_tx[4+i] = pl[i*8 +: 8];
    ex_tx_len = (len == 0) ? 3 : (is_wr ? 4 + len : 4);
    exd = '0;
    if (is_rd && ex_status == 0)
      for (int i = 0; i < ex_count; i++) exd[i*8 +: 8] = rx_b[i+1];
    @(negedge clk);
    n_starts = 0; cur_attempt = 0;
    req_cmd = cmd; req_addr = addr; req_len = LEN_W'(len); req_payload = pl;
    req_valid = 1'b1;
    rsp_ready = (hold == 0);
    @(posedge clk);
    in_flight = 1'b1;
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_status == 3'(ex_status), rq, "status", rsp_status, ex_status);
    chk(rsp_reply == 4'(ex_reply), rq, "reply code", rsp_reply, ex_reply);
    chk(rsp_count == LEN_W'(ex_count), rq, "count", rsp_count, ex_count);
    chk(rsp_data == exd, rq, "read data low word", rsp_data[63:0], exd[63:0]);
    chk(n_starts == ex_starts, "R11", {rq, " launches"}, n_starts, ex_starts);
    if (ex_status == 3)
      chk(cyc - acc_cyc >= (BUSY_POLLS - 1) * POLL_GAP, "R12", "busy poll duration",
          cyc - acc_cyc, (BUSY_POLLS - 1) * POLL_GAP);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_status == 3'(ex_status) && rsp_count == LEN_W'(ex_count),
          "R1", "stalled response held", rsp_status, ex_status);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    in_flight = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: actual 0x%0h expected 0x%0h", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    set_rx(1, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !ch_start, "R1", "reset state",
        {req_ready, rsp_valid, ch_start}, 3'b100);

    // R2 R3: native write, header plus payload
    n_kinds = 0; set_rx(1, 8'h00, 8'h00, 8'h00, 8'h00);
    do_req(4'h8, 20'h12345, 2, 1, 0, 128'hBBAA, 0, 0, 2, 1, "R2", 0);
    // R6: native read, data after reply byte
    set_rx(4, 8'h00, 8'h11, 8'h22, 8'h33);
    do_req(4'h9, 20'h00100, 3, 0, 1, '0, 0, 0, 3, 1, "R6", 0);
    // R3: zero-length continued I2C write sends three bytes
    set_rx(1, 8'h00, 8'h00, 8'h00, 8'h00);
    do_req(4'h4, 20'h00050, 0, 1, 0, '0, 0, 0, 0, 1, "R3", 0);
    // R7: short write count, then clamp to length
    set_rx(2, 8'h10, 8'h02, 8'h00, 8'h00);
    do_req(4'h8, 20'h00200, 4, 1, 0, 128'h44332211, 0, 1, 2, 1, "R7", 0);
    set_rx(2, 8'h00, 8'h09, 8'h00, 8'h00);
    do_req(4'h0, 20'h00201, 4, 1, 0, 128'h44332211, 0, 0, 4, 1, "R7", 0);
    // R5: oversized replies clamp to expected size
    set_rx(10, 8'h00, 8'hC1, 8'hC2, 8'hC3);
    do_req(4'h1, 20'h00300, 2, 0, 1, '0, 0, 0, 2, 1, "R5", 0);
    set_rx(5, 8'h00, 8'h03, 8'h00, 8'h00);
    do_req(4'h2, 20'h00301, 4, 1, 0, 128'h1, 0, 0, 3, 1, "R5", 0);
    // R8: illegal received sizes
    set_rx(21, 8'h00, 8'h00, 8'h00, 8'h00);
    do_req(4'h9, 20'h00400, 2, 0, 1, '0, 4, 0, 0, 1, "R8", 0);
    set_rx(0, 8'h00, 8'h00, 8'h00, 8'h00);
    do_req(4'h9, 20'h00401, 2, 0, 1, '0, 4, 0, 0, 1, "R8", 0);
    // R9: two timeouts then success
    n_kinds = 2; out_kind[0] = 1; out_kind[1] = 1;
    set_rx(2, 8'h00, 8'h5A, 8'h00, 8'h00);
    do_req(4'h9, 20'h00500, 1, 0, 1, '0, 0, 0, 1, 3, "R9", 0);
    // R10: receive error, and both flags, then success
    n_kinds = 1; out_kind[0] = 2; set_rx(1, 8'h00, 8'h00, 8'h00, 8'h00);
    do_req(4'h8, 20'h00600, 1, 1, 0, 128'h7E, 0, 0, 1, 2, "R10", 0);
    n_kinds = 1; out_kind[0] = 3;
    do_req(4'h8, 20'h00601, 1, 1, 0, 128'h7F, 0, 0, 1, 2, "R10", 0);
    // R11: exhausted attempts
    n_kinds = 5; for (int i = 0; i < 5; i++) out_kind[i] = 1;
    do_req(4'h9, 20'h00700, 1, 0, 1, '0, 2, 0, 0, 5, "R11", 0);
    for (int i = 0; i < 5; i++) out_kind[i] = (i == 4) ? 3 : 2;
    do_req(4'h9, 20'h00701, 1, 0, 1, '0, 1, 0, 0, 5, "R11", 0);
    n_kinds = 0;
    // R4: invalid command and length
    do_req(4'h3, 20'h00800, 1, 0, 0, '0, 5, 0, 0, 0, "R4", 0);
    do_req(4'h9, 20'h00801, 17, 0, 0, '0, 5, 0, 0, 0, "R4", 0);
    // R12: channel never frees, then frees after a while
    ch_busy = 1'b1;
    do_req(4'h9, 20'h00900, 1, 0, 1, '0, 3, 0, 0, 0, "R12", 0);
    fork
      begin repeat (20) @(negedge clk); ch_busy = 1'b0; end
    join_none
    set_rx(2, 8'h00, 8'h66, 8'h00, 8'h00);
    do_req(4'h9, 20'h00901, 1, 0, 1, '0, 0, 0, 1, 1, "R12", 0);
    // R6 + R1: deferral code passed up, response stalled by consumer
    set_rx(2, 8'h20, 8'h77, 8'h00, 8'h00);
    do_req(4'h9, 20'h00A00, 1, 0, 1, '0, 0, 2, 1, 1, "R6", 4);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule